// File: doc/BRIEF.md
# Card Response Capture Register Bank

This block collects a command response that a memory card sends one bit at a time on its command line. It then exposes the response as four read-only 32-bit words. A controlling command state machine pulses `cap_start` when a response begins and sets `cap_long` to choose the response type. The bits of the response follow on `cmd_bit`. Each one is qualified by `bit_strobe`, a single-cycle enable that marks a card bus clock sample. The most significant status bit arrives first.

A short response carries a 32-bit status field. A long response carries 127 bits, and its implied final bit is always zero. The bits first build up in a hidden shift register. Only after the last bit arrives does the visible word bank load, with all four words at once. The one-cycle `cap_done` pulse marks that load. Software reads the words through a small combinational address/data port.

The control machine has three states. In IDLE it waits for a start. SHIFT accepts strobed bits. COMMIT lasts one cycle and loads the visible words. The transitions are: IDLE to SHIFT on `cap_start` (this is where `cap_long` is latched), SHIFT to COMMIT on the strobe that carries the final bit, and COMMIT to IDLE unconditionally.

Top module: `resp_capture_top`

## Requirements
- R1: After reset all four words read 0x00000000 and `cap_done` is low.
- R2: A short capture takes 32 strobed bits, first bit to most significant. Word 1 (address 0x14) then holds them, and words 2 to 4 read zero afterwards.
- R3: A long capture takes 127 strobed bits forming status[127:1], first bit being status[127]. Word 1 = status[127:96], word 2 = [95:64], word 3 = [63:32], word 4 = {status[31:1], 0}, so word 4 bit 0 is always 0.
- R4: Words 1 to 4 are read at byte addresses 0x14, 0x18, 0x1C and 0x20. Any other address reads 0x00000000.
- R5: `cmd_bit` is taken only on cycles where `bit_strobe` is high while a capture is active. Values on other cycles have no effect on the result.
- R6: During a capture the visible words keep their previous values. They change only on the cycle `cap_done` is high.
- R7: `cap_done` goes high for exactly one cycle. It is high in the second cycle after the clock edge that takes the final bit, and the new words are readable in that same cycle.
- R8: `cap_long` is sampled only with `cap_start` in IDLE. Changing it during a capture does not alter the length or the mapping.
- R9: `cap_start` during an active capture is ignored. The capture neither restarts nor ends early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_start | input | 1 | Begin a capture (honoured in IDLE only) |
| cap_long | input | 1 | 1 = long 127-bit response, 0 = short 32-bit response |
| bit_strobe | input | 1 | Marks a cycle that carries a response bit |
| cmd_bit | input | 1 | Serial response bit, most significant first |
| rd_addr | input | 8 | Byte address of the word to read |
| rd_data | output | 32 | Read data (combinational from `rd_addr`) |
| cap_done | output | 1 | One-cycle pulse when the new words become visible |

## Verification
The bench counts edges from the final strobed bit. The edge that takes that bit is followed by the COMMIT edge. Both `cap_done` and the new words therefore appear in the second cycle, and the bench samples them at the falling edge after that COMMIT edge. It checks `cap_done` low one sample earlier and again one sample later. Expected words go into a queue as soon as the driver has sent the last bit. A monitor pops them on the cycle `cap_done` is seen and reads all four addresses within that low clock phase. Reads of the old word partway through a capture, and reads of unmapped addresses, are made while the machine is busy or idle, never on a done cycle.

// File: rtl/resp_cap_pkg.sv
package resp_cap_pkg;

    // Control machine states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } cap_state_t;

    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 4;
    localparam int SHORT_BITS = 32;
    localparam int LONG_BITS  = 127;

endpackage

// File: rtl/resp_cap_fsm.sv
module resp_cap_fsm
    import resp_cap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       long_i,
    input  logic       last_bit_i,
    output cap_state_t state_o,
    output logic       long_q_o,
    output logic       clear_o,
    output logic       shifting_o,
    output logic       commit_o,
    output logic       done_o
);

    cap_state_t state_q, state_d;
    logic       long_q;
    logic       done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            long_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_COMMIT);
            if (state_q == ST_IDLE && start_i) begin
                long_q <= long_i;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)    state_d = ST_SHIFT;
            ST_SHIFT:  if (last_bit_i) state_d = ST_COMMIT;
            ST_COMMIT:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clear_o    = 1'b0;
        shifting_o = 1'b0;
        commit_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   clear_o    = start_i;
            ST_SHIFT:  shifting_o = 1'b1;
            ST_COMMIT: commit_o   = 1'b1;
            default:   ;
        endcase
    end

    assign state_o  = state_q;
    assign long_q_o = long_q;
    assign done_o   = done_q;

endmodule

// File: rtl/resp_cap_shifter.sv
module resp_cap_shifter #(
    parameter int SHORT_BITS = 32,
    parameter int LONG_BITS  = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 shift_en_i,
    input  logic                 bit_i,
    input  logic                 long_i,
    output logic [LONG_BITS-1:0] shreg_o,
    output logic                 last_o
);

    localparam int CNT_W = $clog2(LONG_BITS + 1);

    logic [LONG_BITS-1:0] shreg;
    logic [CNT_W-1:0]     count;
    logic [CNT_W-1:0]     final_idx;

    assign final_idx = long_i ? CNT_W'(LONG_BITS - 1) : CNT_W'(SHORT_BITS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            count <= '0;
        end else if (clear_i) begin
            shreg <= '0;
            count <= '0;
        end else if (shift_en_i) begin
            shreg <= {shreg[LONG_BITS-2:0], bit_i};
            count <= count + 1'b1;
        end
    end

    assign last_o  = shift_en_i && (count == final_idx);
    assign shreg_o = shreg;

endmodule

// File: rtl/resp_cap_regs.sv
module resp_cap_regs #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int LONG_BITS = 127,
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h10,
    parameter int STRIDE    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 commit_i,
    input  logic                 long_i,
    input  logic [LONG_BITS-1:0] shreg_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [WORD_W-1:0]    rd_data_o
);

    localparam int TOTAL_W = WORD_W * NUM_WORDS;

    logic [TOTAL_W-1:0] long_img;
    logic [WORD_W-1:0]  words [NUM_WORDS];

    // long image: received bits followed by the implied zero bit
    assign long_img = {shreg_i, 1'b0};

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        logic [WORD_W-1:0] next_w;
        always_comb begin
            if (long_i)
                next_w = long_img[TOTAL_W-1-WORD_W*gi -: WORD_W];
            else if (gi == 0)
                next_w = shreg_i[WORD_W-1:0];
            else
                next_w = '0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[gi] <= '0;
            else if (commit_i)
                words[gi] <= next_w;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_addr_i == ADDR_W'(BASE_ADDR + STRIDE * (i + 1)))
                rd_data_o = words[i];
        end
    end

endmodule

// File: rtl/resp_capture_top.sv
module resp_capture_top
    import resp_cap_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 'h10,
    parameter int STRIDE    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              cap_long,
    input  logic              bit_strobe,
    input  logic              cmd_bit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              cap_done
);

    cap_state_t           state;
    logic                 long_q;
    logic                 clear;
    logic                 shifting;
    logic                 commit;
    logic                 last_bit;
    logic [LONG_BITS-1:0] shreg;

    resp_cap_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (cap_start),
        .long_i     (cap_long),
        .last_bit_i (last_bit),
        .state_o    (state),
        .long_q_o   (long_q),
        .clear_o    (clear),
        .shifting_o (shifting),
        .commit_o   (commit),
        .done_o     (cap_done)
    );

    resp_cap_shifter #(
        .SHORT_BITS (SHORT_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .shift_en_i (shifting && bit_strobe),
        .bit_i      (cmd_bit),
        .long_i     (long_q),
        .shreg_o    (shreg),
        .last_o     (last_bit)
    );

    resp_cap_regs #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .LONG_BITS (LONG_BITS),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .STRIDE    (STRIDE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .long_i    (long_q),
        .shreg_i   (shreg),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

endmodule

// File: rtl/resp_capture_chk.sv
module resp_capture_chk
    import resp_cap_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cap_start,
    input logic [7:0] rd_addr,
    input logic [31:0] rd_data,
    input logic       cap_done,
    input cap_state_t state
);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !cap_done);

    // R7
    done_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |-> $past(state) == ST_COMMIT);

    // R6
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_done && $stable(rd_addr)) |-> $stable(rd_data));

    // R3
    word4_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 8'h20) |-> !rd_data[0]);

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_addr inside {8'h14, 8'h18, 8'h1C, 8'h20}) |-> rd_data == 32'h0);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cap_start) |=> state != ST_IDLE);

endmodule

bind resp_capture_top resp_capture_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_start (cap_start),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cap_done  (cap_done),
    .state     (state)
);

// File: tb/resp_capture_top_test.sv
module resp_capture_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_start = 1'b0;
    logic        cap_long = 1'b0;
    logic        bit_strobe = 1'b0;
    logic        cmd_bit = 1'b0;
    logic [7:0]  rd_addr = 8'h00;
    logic [31:0] rd_data;
    logic        cap_done;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] last_w1 = 32'h0;

    always #10 clk = ~clk;

    resp_capture_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_start  (cap_start),
        .cap_long   (cap_long),
        .bit_strobe (bit_strobe),
        .cmd_bit    (cmd_bit),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cap_done   (cap_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    function automatic logic [127:0] make_pat(input logic [31:0] seed);
        logic [31:0] s = seed;
        logic [127:0] r;
        for (int i = 0; i < 4; i++) begin
            s = s ^ (s << 13);
            s = s ^ (s >> 17);
            s = s ^ (s << 5);
            r[32*i +: 32] = s;
        end
        return r;
    endfunction

    // driver: runs one capture and queues the expected words
    task automatic capture(input bit lng, input logic [127:0] st, input int gap,
                           input bit noise, input string tag);
        int n = lng ? 127 : 32;
        int top = lng ? 127 : 31;
        logic [127:0] img;
        @(negedge clk);
        cap_start = 1'b1;
        cap_long  = lng;
        @(negedge clk);
        cap_start = 1'b0;
        if (noise) cap_long = ~lng;  // R8
        for (int k = 0; k < n; k++) begin
            cmd_bit    = st[top - k];
            bit_strobe = 1'b1;
            if (noise && k == 5) cap_start = 1'b1;  // R9
            @(negedge clk);
            cap_start  = 1'b0;
            bit_strobe = 1'b0;
            if (k == n / 2)
                read_chk({tag, " R6 partial hidden"}, 8'h14, last_w1);
            if (k != n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    cmd_bit = ~cmd_bit;  // R5 noise on unstrobed cycles
                    @(negedge clk);
                end
            end
        end
        if (lng) begin
            img = {st[127:1], 1'b0};
            exp_q.push_back('{8'h14, img[127:96], {tag, " R3 w1"}});
            exp_q.push_back('{8'h18, img[95:64],  {tag, " R3 w2"}});
            exp_q.push_back('{8'h1C, img[63:32],  {tag, " R3 w3"}});
            exp_q.push_back('{8'h20, img[31:0],   {tag, " R3 w4"}});
            last_w1 = img[127:96];
        end else begin
            exp_q.push_back('{8'h14, st[31:0], {tag, " R2 w1"}});
            exp_q.push_back('{8'h18, 32'h0,    {tag, " R2 w2"}});
            exp_q.push_back('{8'h1C, 32'h0,    {tag, " R2 w3"}});
            exp_q.push_back('{8'h20, 32'h0,    {tag, " R2 w4"}});
            last_w1 = st[31:0];
        end
        // one edge after the final bit: not yet done
        check({tag, " R7 done early"}, {31'h0, cap_done}, 32'h0);
        @(negedge clk);
        check({tag, " R7 done due"}, {31'h0, cap_done}, 32'h1);
        @(negedge clk);
        check({tag, " R7 done width"}, {31'h0, cap_done}, 32'h0);
        cap_long = 1'b0;
    endtask

    // monitor: pops expected words when done appears
    initial begin
        forever begin
            @(negedge clk);
            if (cap_done === 1'b1) begin
                for (int i = 0; i < 4; i++) begin
                    exp_t e;
                    if (exp_q.size() == 0) begin
                        check("R7 unexpected done", 32'h1, 32'h0);
                        break;
                    end
                    e = exp_q.pop_front();
                    read_chk(e.tag, e.addr, e.data);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", {31'h0, cap_done}, 32'h0);
        read_chk("R1 w1", 8'h14, 32'h0);
        read_chk("R1 w2", 8'h18, 32'h0);
        read_chk("R1 w3", 8'h1C, 32'h0);
        read_chk("R1 w4", 8'h20, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", {31'h0, cap_done}, 32'h0);

        capture(1'b0, make_pat(32'h1234_5678), 0, 1'b0, "short");
        capture(1'b1, make_pat(32'hCAFE_0001), 0, 1'b0, "long");
        // R4 unmapped addresses while words are non-zero
        read_chk("R4 0x10", 8'h10, 32'h0);
        read_chk("R4 0x24", 8'h24, 32'h0);
        read_chk("R4 0x15", 8'h15, 32'h0);
        read_chk("R4 0x00", 8'h00, 32'h0);
        // R5 gaps with toggling line
        capture(1'b1, make_pat(32'h0BAD_F00D), 2, 1'b0, "long gap R5");
        // short after long clears upper words
        capture(1'b0, make_pat(32'h7777_0003), 1, 1'b0, "short gap R5");
        // R8 / R9 select flip and stray start mid-capture
        capture(1'b0, make_pat(32'h5555_1111), 0, 1'b1, "short noise R8 R9");
        capture(1'b1, make_pat(32'hFFFF_FFFF), 0, 1'b1, "long noise R8 R9");
        capture(1'b1, {128{1'b1}}, 0, 1'b0, "long ones R3");
        repeat (3) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 32'h0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule